// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block watches the receive byte stream of an Ethernet MAC. It decides from the destination address alone whether the frame is kept. The first six bytes after a start-of-frame marker are taken as the destination. While they arrive, a CRC-32 is accumulated over them. Each byte is also compared against the programmed station address and tested for the all-ones broadcast pattern.

After the sixth byte the block issues a single decision strobe. An accept bit and a miss bit travel with the strobe and then hold steady until the next frame starts. There are three mode inputs:
- one rejects broadcasts;
- one forces every non-broadcast destination through the hash table;
- one accepts every frame (promiscuous) while the miss flag still reports whether the address matched.

A frame that ends before its destination is complete is rejected at its last byte. The bytes that follow the destination are ignored. The surrounding MAC uses the accept bit to commit or drop the frame, and can log the miss bit when in promiscuous mode.

Top module: `eth_rx_dest_filter`

## Requirements
- R1: A destination whose six bytes are all 0xFF is broadcast. It is a hit when `cfg_bcast_rej` is 0 and a miss when it is 1, whatever the station address and hash table hold.
- R2: A destination that is not broadcast goes to the hash check when bit 0 of its first byte is 1 or when `cfg_hash_all` is 1; otherwise it goes to the station address compare.
- R3: The hash index is bits 31:26 of the inverted final CRC over the six destination bytes. The CRC uses reflected polynomial 0xEDB88320, starts at all ones, and takes each byte LSB first. The destination is a hit when bit `index` of `hash_tbl` is 1, so bits 31:0 form the lower table word and bits 63:32 the upper word.
- R4: On the station compare path, destination bytes 0 and 1 must equal `stn_addr_hi[15:8]` and `[7:0]`, and bytes 2 to 5 must equal `stn_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any difference is a miss.
- R5: The outputs are `dec_miss` = not hit and `dec_accept` = hit or `cfg_promisc`. In promiscuous mode a missed frame is accepted with `dec_miss` = 1.
- R6: `dec_vld` is high for exactly one cycle, the cycle after the sixth destination byte is taken. There is exactly one decision per frame, and bytes after the sixth do not create another.
- R7: `dec_accept` and `dec_miss` keep their decision values until a start-of-frame byte is taken. They read 0 in the cycle after that byte.
- R8: A frame whose end marker comes on byte 1 to 5 gets a decision in the cycle after that byte, with `dec_accept` = 0 and `dec_miss` = 1, even in promiscuous mode.
- R9: A start-of-frame byte taken while a destination is only partly collected discards the partial address and starts a new one, so the abandoned frame yields no decision.
- R10: After reset, `dec_vld`, `dec_accept` and `dec_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_vld | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_eof | input | 1 | The present byte is the last byte of a frame |
| rx_byte | input | 8 | Receive data byte |
| stn_addr_hi | input | 16 | Station address, destination bytes 0 and 1 |
| stn_addr_lo | input | 32 | Station address, destination bytes 2 to 5 |
| hash_tbl | input | 64 | Group address hash table |
| cfg_bcast_rej | input | 1 | Treat broadcast as a miss |
| cfg_hash_all | input | 1 | Send individual addresses through the hash table |
| cfg_promisc | input | 1 | Accept frames that miss |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_miss | output | 1 | Destination missed every filter |

## Verification
A wrong CRC register or comparison flag does not show until the decision strobe of that frame. It then appears as a flipped accept or miss bit one cycle after the sixth byte. For that reason each path (broadcast, hash hit and miss, station match and mismatch at the first and last byte) is checked against independently computed expectations. A wrong byte counter shows at the ports as a strobe in the wrong cycle, a missing strobe or an extra strobe. The scoreboard catches an unexpected strobe immediately and a missing one at the end of the run. Hold and clear faults are caught by sampling the outputs two idle cycles after a decision and one cycle after the next start-of-frame byte.

// File: rtl/eth_dafilt_pkg.sv
package eth_dafilt_pkg;

   typedef struct packed {
      logic accept;
      logic miss;
   } dafilt_dec_t;

   // one byte of a reflected CRC, LSB first
   function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                 input logic [7:0]  data,
                                                 input logic [31:0] poly);
      logic [31:0] c;
      c = crc_in ^ {24'd0, data};
      for (int b = 0; b < 8; b++) begin
         c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/eth_dafilt_crc.sv
module eth_dafilt_crc #(
   parameter int          CRC_W     = 32,
   parameter logic [31:0] CRC_POLY  = 32'hEDB8_8320,
   parameter int          HASH_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 first,
   input  logic [7:0]           din,
   output logic [HASH_BITS-1:0] hash_idx
);
   import eth_dafilt_pkg::*;

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_seed;
   logic [CRC_W-1:0] crc_nxt;

   assign crc_seed = first ? {CRC_W{1'b1}} : crc_q;
   assign crc_nxt  = crc_step_byte(crc_seed, din, CRC_POLY);

   // index taken from the inverted running value including this byte
   assign hash_idx = ~crc_nxt[CRC_W-1 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= {CRC_W{1'b1}};
      end else if (step) begin
         crc_q <= crc_nxt;
      end
   end

endmodule

// File: rtl/eth_dafilt_cmp.sv
module eth_dafilt_cmp #(
   parameter int ADDR_BYTES = 6,
   localparam int POS_W     = $clog2(ADDR_BYTES),
   localparam int ADDR_W    = ADDR_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              first,
   input  logic [POS_W-1:0]  pos,
   input  logic [7:0]        din,
   input  logic [ADDR_W-1:0] stn_addr,
   output logic              uc_eq,
   output logic              all_ones,
   output logic              grp_bit
);

   logic [7:0] exp_byte [ADDR_BYTES];
   logic [7:0] exp_sel;
   logic       eq_q;
   logic       ones_q;
   logic       grp_q;

   // destination byte k lines up with the k-th most significant address byte
   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_exp
      assign exp_byte[k] = stn_addr[(ADDR_BYTES-1-k)*8 +: 8];
   end

   always_comb begin
      exp_sel = exp_byte[pos];
   end

   assign uc_eq    = (first | eq_q)   & (din == exp_sel);
   assign all_ones = (first | ones_q) & (&din);
   assign grp_bit  = first ? din[0] : grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eq_q   <= 1'b0;
         ones_q <= 1'b0;
         grp_q  <= 1'b0;
      end else if (step) begin
         eq_q   <= uc_eq;
         ones_q <= all_ones;
         grp_q  <= grp_bit;
      end
   end

endmodule

// File: rtl/eth_dafilt_seq.sv
module eth_dafilt_seq #(
   parameter int ADDR_BYTES = 6,
   localparam int POS_W     = $clog2(ADDR_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_vld,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             all_ones,
   input  logic             grp_bit,
   input  logic             uc_eq,
   input  logic             hash_hit,
   input  logic             cfg_bcast_rej,
   input  logic             cfg_hash_all,
   input  logic             cfg_promisc,
   output logic             step,
   output logic             first,
   output logic [POS_W-1:0] pos,
   output logic             dec_vld,
   output eth_dafilt_pkg::dafilt_dec_t dec
);
   import eth_dafilt_pkg::*;

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

   logic             collecting_q;
   logic [POS_W-1:0] cnt_q;
   logic             is_last;
   logic             is_short;
   logic             use_hash;
   logic             hit;
   dafilt_dec_t      dec_q;
   logic             dec_vld_q;

   assign step     = rx_vld & (rx_sof | collecting_q);
   assign first    = rx_vld & rx_sof;
   assign pos      = rx_sof ? '0 : cnt_q;
   assign is_last  = step & (pos == LAST_POS);
   assign is_short = step & rx_eof & ~is_last;

   assign use_hash = ~all_ones & (grp_bit | cfg_hash_all);
   assign hit      = all_ones ? ~cfg_bcast_rej : (use_hash ? hash_hit : uc_eq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         collecting_q <= 1'b0;
         cnt_q        <= '0;
      end else if (step) begin
         if (is_last || is_short) begin
            collecting_q <= 1'b0;
            cnt_q        <= '0;
         end else begin
            collecting_q <= 1'b1;
            cnt_q        <= pos + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld_q <= 1'b0;
         dec_q     <= '0;
      end else begin
         dec_vld_q <= is_last | is_short;
         if (is_last) begin
            dec_q.accept <= hit | cfg_promisc;
            dec_q.miss   <= ~hit;
         end else if (is_short) begin
            dec_q.accept <= 1'b0;
            dec_q.miss   <= 1'b1;
         end else if (first) begin
            dec_q <= '0;
         end
      end
   end

   assign dec_vld = dec_vld_q;
   assign dec     = dec_q;

endmodule

// File: rtl/eth_rx_dest_filter.sv
module eth_rx_dest_filter #(
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter logic [31:0] CRC_POLY   = 32'hEDB8_8320,
   localparam int         HASH_SIZE  = 1 << HASH_BITS,
   localparam int         POS_W      = $clog2(ADDR_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_vld,
   input  logic                 rx_sof,
   input  logic                 rx_eof,
   input  logic [7:0]           rx_byte,
   input  logic [15:0]          stn_addr_hi,
   input  logic [31:0]          stn_addr_lo,
   input  logic [HASH_SIZE-1:0] hash_tbl,
   input  logic                 cfg_bcast_rej,
   input  logic                 cfg_hash_all,
   input  logic                 cfg_promisc,
   output logic                 dec_vld,
   output logic                 dec_accept,
   output logic                 dec_miss
);
   import eth_dafilt_pkg::*;

   // the station address is split over a 16-bit and a 32-bit register
   if (ADDR_BYTES != 6) begin : g_bad_addr
      $error("ADDR_BYTES must be 6 to match the station address registers");
   end
   if (HASH_BITS < 1 || HASH_BITS > 12) begin : g_bad_hash
      $error("HASH_BITS out of range");
   end

   logic                 step;
   logic                 first;
   logic [POS_W-1:0]     pos;
   logic [HASH_BITS-1:0] hash_idx;
   logic                 uc_eq;
   logic                 all_ones;
   logic                 grp_bit;
   logic                 hash_hit;
   dafilt_dec_t          dec;

   eth_dafilt_crc #(
      .CRC_W     (32),
      .CRC_POLY  (CRC_POLY),
      .HASH_BITS (HASH_BITS)
   ) crc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .first    (first),
      .din      (rx_byte),
      .hash_idx (hash_idx)
   );

   eth_dafilt_cmp #(
      .ADDR_BYTES (ADDR_BYTES)
   ) cmp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .first    (first),
      .pos      (pos),
      .din      (rx_byte),
      .stn_addr ({stn_addr_hi, stn_addr_lo}),
      .uc_eq    (uc_eq),
      .all_ones (all_ones),
      .grp_bit  (grp_bit)
   );

   assign hash_hit = hash_tbl[hash_idx];

   eth_dafilt_seq #(
      .ADDR_BYTES (ADDR_BYTES)
   ) seq_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_vld        (rx_vld),
      .rx_sof        (rx_sof),
      .rx_eof        (rx_eof),
      .all_ones      (all_ones),
      .grp_bit       (grp_bit),
      .uc_eq         (uc_eq),
      .hash_hit      (hash_hit),
      .cfg_bcast_rej (cfg_bcast_rej),
      .cfg_hash_all  (cfg_hash_all),
      .cfg_promisc   (cfg_promisc),
      .step          (step),
      .first         (first),
      .pos           (pos),
      .dec_vld       (dec_vld),
      .dec           (dec)
   );

   assign dec_accept = dec.accept;
   assign dec_miss   = dec.miss;

endmodule

// File: rtl/eth_dafilt_chk.sv
module eth_dafilt_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_vld,
   input logic rx_sof,
   input logic rx_eof,
   input logic cfg_promisc,
   input logic dec_vld,
   input logic dec_accept,
   input logic dec_miss
);

   // R5: a hit is always accepted
   assert_hit_accepted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld && !dec_miss |-> dec_accept);

   // R5: without promiscuous mode a miss is rejected
   assert_miss_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld && dec_miss && !$past(cfg_promisc) |-> !dec_accept);

   // R8: a one-byte frame is rejected at once
   assert_short_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld && rx_sof && rx_eof |=> dec_vld && dec_miss && !dec_accept);

   // R7: a new frame start clears the held decision
   assert_clear_on_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld && rx_sof && !rx_eof |=> !dec_vld && !dec_accept && !dec_miss);

   // R7: outside a strobe or a clear the decision holds
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld && !$past(rx_vld && rx_sof) |-> $stable(dec_accept) && $stable(dec_miss));

endmodule

bind eth_rx_dest_filter eth_dafilt_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_vld      (rx_vld),
   .rx_sof      (rx_sof),
   .rx_eof      (rx_eof),
   .cfg_promisc (cfg_promisc),
   .dec_vld     (dec_vld),
   .dec_accept  (dec_accept),
   .dec_miss    (dec_miss)
);

// File: tb/eth_rx_dest_filter_tb_top.sv
module eth_rx_dest_filter_tb_top;

   typedef struct {
      logic  acc;
      logic  miss;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_vld = 1'b0;
   logic        rx_sof = 1'b0;
   logic        rx_eof = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [15:0] stn_addr_hi = 16'h0A1B;
   logic [31:0] stn_addr_lo = 32'h2C3D4E5F;
   logic [63:0] hash_tbl = 64'd0;
   logic        cfg_bcast_rej = 1'b0;
   logic        cfg_hash_all = 1'b0;
   logic        cfg_promisc = 1'b0;
   logic        dec_vld;
   logic        dec_accept;
   logic        dec_miss;

   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;
   exp_t        sb_q [$];
   logic [7:0]  frm [16];

   always #4 clk = ~clk;

   eth_rx_dest_filter dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_vld        (rx_vld),
      .rx_sof        (rx_sof),
      .rx_eof        (rx_eof),
      .rx_byte       (rx_byte),
      .stn_addr_hi   (stn_addr_hi),
      .stn_addr_lo   (stn_addr_lo),
      .hash_tbl      (hash_tbl),
      .cfg_bcast_rej (cfg_bcast_rej),
      .cfg_hash_all  (cfg_hash_all),
      .cfg_promisc   (cfg_promisc),
      .dec_vld       (dec_vld),
      .dec_accept    (dec_accept),
      .dec_miss      (dec_miss)
   );

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual accept/miss=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // hash index from the requirement: inverted reflected CRC, bits 31:26
   function automatic int hash_of_frame();
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         c = c ^ {24'd0, frm[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      c = ~c;
      return int'(c[31:26]);
   endfunction

   function automatic exp_t model(input int len, input string tag);
      exp_t  e;
      logic  hit;
      logic  bc;
      e.tag = tag;
      if (len < 6) begin
         e.acc = 1'b0; e.miss = 1'b1;
         return e;
      end
      bc = 1'b1;
      for (int i = 0; i < 6; i++) if (frm[i] != 8'hFF) bc = 1'b0;
      if (bc) hit = !cfg_bcast_rej;
      else if (frm[0][0] || cfg_hash_all) hit = hash_tbl[hash_of_frame()];
      else hit = (frm[0] == stn_addr_hi[15:8]) && (frm[1] == stn_addr_hi[7:0]) &&
                 (frm[2] == stn_addr_lo[31:24]) && (frm[3] == stn_addr_lo[23:16]) &&
                 (frm[4] == stn_addr_lo[15:8]) && (frm[5] == stn_addr_lo[7:0]);
      e.miss = !hit;
      e.acc  = hit || cfg_promisc;
      return e;
   endfunction

   task automatic set_frame(input logic [47:0] da);
      for (int i = 0; i < 6; i++) frm[i] = da[47-8*i -: 8];
      for (int i = 6; i < 16; i++) frm[i] = 8'(8'h30 + i);
   endtask

   // drive a frame; with_eof=0 leaves it open (abandoned); chk_clear checks R7 clear
   task automatic send(input int len, input logic with_eof, input logic chk_clear,
                       input string tag);
      exp_t e;
      e = model(len, tag);
      if (with_eof || len >= 6) sb_q.push_back(e);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == 1 && chk_clear) check("R7 clear on new frame", {dec_accept, dec_miss}, 2'b00);
         rx_vld  = 1'b1;
         rx_sof  = (i == 0);
         rx_eof  = with_eof && (i == len - 1);
         rx_byte = frm[i];
      end
      @(negedge clk);
      rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      repeat (2) @(negedge clk);
      if (len >= 6) check({"R7 hold ", tag}, {dec_accept, dec_miss}, {e.acc, e.miss});
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && dec_vld) begin
         if (sb_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6 unexpected decision actual=1 expected=0");
         end else begin
            e = sb_q.pop_front();
            check(e.tag, {dec_accept, dec_miss}, {e.acc, e.miss});
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<20000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset", {dec_accept, dec_miss}, 2'b00);
      checks++;
      if (dec_vld !== 1'b0) begin errors++; $display("FAIL R10 dec_vld actual=%b expected=0", dec_vld); end
      rst_n = 1'b1;
      @(negedge clk);

      set_frame(48'h0A1B_2C3D_4E5F); send(8, 1, 0, "R4 station match");
      set_frame(48'h0A1B_2C3D_4E5E); send(8, 1, 1, "R4 mismatch last byte");
      set_frame(48'h0A1C_2C3D_4E5F); send(6, 1, 1, "R4 mismatch byte 1");
      set_frame(48'hFFFF_FFFF_FFFF); send(7, 1, 1, "R1 broadcast allowed");
      cfg_bcast_rej = 1'b1;
      send(7, 1, 1, "R1 broadcast rejected");
      cfg_bcast_rej = 1'b0;

      set_frame(48'h0100_5E00_00FB);
      hash_tbl = 64'd1 << hash_of_frame();
      send(9, 1, 1, "R3 group hash hit");
      hash_tbl = ~(64'd1 << hash_of_frame());
      send(9, 1, 1, "R3 group hash miss");

      set_frame(48'h0A1B_2C3D_4E5F);
      hash_tbl = ~(64'd1 << hash_of_frame());
      cfg_hash_all = 1'b1;
      send(8, 1, 1, "R2 hash-all overrides station match");
      hash_tbl = 64'd1 << hash_of_frame();
      send(8, 1, 1, "R2 hash-all hit");
      cfg_hash_all = 1'b0;
      hash_tbl = 64'hFFFF_FFFF_FFFF_FFFF;
      set_frame(48'h0A1B_2C3D_4E5E); send(8, 1, 1, "R2 individual ignores full table");

      cfg_promisc = 1'b1;
      set_frame(48'h1234_5678_9ABC); send(8, 1, 1, "R5 promiscuous miss");
      set_frame(48'h0A1B_2C3D_4E5F); send(8, 1, 1, "R5 promiscuous hit");
      set_frame(48'h0A1B_2C3D_4E5F); send(3, 1, 1, "R8 short in promiscuous");
      cfg_promisc = 1'b0;
      send(1, 1, 0, "R8 one byte frame");
      send(5, 1, 0, "R8 five byte frame");

      set_frame(48'hFFFF_FFFF_FFFF); send(3, 0, 0, "R9 abandoned");
      set_frame(48'h0A1B_2C3D_4E5F); send(6, 1, 1, "R9 restart then match");
      send(12, 1, 0, "R6 single decision on long frame");

      repeat (4) @(negedge clk);
      checks++;
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R6 missing decisions actual=%0d expected=0", sb_q.size());
      end
      finish_run();
   end

endmodule